// File: doc/BRIEF.md
# Character-Cell CRT Timing Generator

This block produces the raster timing for a display built from character cells. One clock cycle is one character time. A column counter sweeps each scan line. A row counter and a scan-line-within-row counter step the frame from top to bottom. A short run of extra adjust lines can follow the last row so that the frame reaches an exact line total. Every total, width and position is a configuration input counted in characters, rows or scan lines. The block derives horizontal and vertical sync, display enable and a blanking output from those counts. The blanking output can also be forced over any column window.

For each visible cell the block forms the screen memory address from three terms: a start address, a row stride, and the column. The row stride is the displayed column count plus an extra per-row skip. The block supports a smooth-scroll offset that trims the top of the first row. It also supports three interlace modes, encoded on a 2-bit input:
- code 0 or 2: no interlace.
- code 1: alternating fields, same lines in each field.
- code 3: each field draws every other scan line of each cell.

A frame counter advances at each vertical sync, for use by cursor and flash blink logic. A light pen input latches the row and column under the beam and raises a flag, which a read strobe clears.

Top module: `crtc_timing`

## Requirements
- R1: `col_o` counts 0 up to `h_total_i` and then returns to 0. Each wrap ends one scan line.
- R2: `hsync_o` is high when `col_o` is at least `hs_pos_i` and below `hs_pos_i + hs_wid_i - 1`. A width code of 0 or 1 gives no pulse, and the pulse never wraps past the line end.
- R3: A frame has rows 0 to `v_total_i`. Each row runs scan lines up to `cell_last_i`. After the last row come `v_adj_i` adjust lines, during which `row_o` holds `v_total_i` and `line_o` counts 0 up to `v_adj_i - 1`.
- R4: `de_o` is high only when `col_o < h_disp_i`, `row_o < v_disp_i` and the line is not an adjust line. `blank_o` is high whenever `de_o` is low.
- R5: `blank_o` is also forced high over a column window. When `hb_begin_i < hb_end_i` the window is `hb_begin_i <= col_o < hb_end_i`. When `hb_begin_i > hb_end_i` the window wraps: `col_o >= hb_begin_i` or `col_o < hb_end_i`. Equal values disable the window.
- R6: `addr_o` equals `start_addr_i + row_o * (h_disp_i + row_inc_i) + col_o`, modulo 2^16.
- R7: `vsync_o` rises on the first scan line of row `vs_pos_i` and stays high for `vs_wid_i` scan lines, where code 0 means 16. Row 0 of the first frame after reset does not start a pulse.
- R8: `frame_o` increments (modulo 2^FW) on the clock edge where `vsync_o` rises, and holds otherwise.
- R9: Row 0 of every frame starts at scan line `scroll_i`, so the first row is shortened by that many lines.
- R10: When `ilace_i[0]` is 1, `field_o` toggles at each frame end. When `ilace_i[0]` is 0 (codes 0 and 2), `field_o` stays 0.
- R11: With `ilace_i == 3`, the scan line steps by 2 within a row and starts at the field value (plus any scroll in row 0). A row ends once the next line would pass `cell_last_i`.
- R12: A high-to-low transition on `lpen_ni` latches the row and column of the second cycle after the transition into `lp_row_o`/`lp_col_o` and sets `lp_flag_o`. A single low pulse latches once, however long it stays low.
- R13: A cycle with `lp_rd_i` high clears `lp_flag_o` and leaves the latched row and column unchanged. A latch in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Character clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| h_total_i | input | CW | Characters per line minus 1 |
| h_disp_i | input | CW | Displayed columns |
| hs_pos_i | input | CW | Column where hsync begins |
| hs_wid_i | input | 4 | Hsync width plus 1 |
| hb_begin_i | input | CW | First column of forced blanking |
| hb_end_i | input | CW | Column after forced blanking |
| v_total_i | input | CW | Rows per frame minus 1 |
| v_disp_i | input | CW | Displayed rows |
| cell_last_i | input | LW | Scan lines per row minus 1 |
| v_adj_i | input | LW | Extra adjust lines per frame |
| vs_pos_i | input | CW | Row where vsync begins |
| vs_wid_i | input | 4 | Vsync width in lines, 0 means 16 |
| scroll_i | input | LW | Smooth-scroll line offset |
| ilace_i | input | 2 | Interlace mode code |
| start_addr_i | input | AW | Screen memory start address |
| row_inc_i | input | CW | Extra address skip per row |
| lpen_ni | input | 1 | Light pen strobe, active low |
| lp_rd_i | input | 1 | Light pen read strobe |
| col_o | output | CW | Current column |
| row_o | output | CW | Current row |
| line_o | output | LW | Scan line within row |
| addr_o | output | AW | Screen memory address |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Display enable |
| blank_o | output | 1 | Blanking |
| field_o | output | 1 | Interlace field |
| frame_o | output | FW | Frame counter |
| lp_row_o | output | CW | Latched pen row |
| lp_col_o | output | CW | Latched pen column |
| lp_flag_o | output | 1 | Pen latch flag |

## Verification
Each configuration is swept cycle by cycle across several whole frames. The sweep covers these corner cases:
- A start address near the top of the 16-bit space. A wrong address adder stops wrapping, or uses the displayed count alone as the stride.
- A 16-line vsync that runs across the frame boundary. A design that restarts the pulse at row 0, or treats code 0 as zero, diverges here.
- A wrapped and an empty blanking window.
- A shortened scrolled first row, and each interlace code. The alternating-line mode exposes a design that steps by one line, or that toggles the field for code 2.
- A long light pen low pulse. It catches a level-sensitive latch, which would keep updating the values, and a clear that also wipes the latched position.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  typedef enum logic [1:0] {
    ILACE_NONE  = 2'd0,
    ILACE_SYNC  = 2'd1,
    ILACE_NONE2 = 2'd2,
    ILACE_VIDEO = 2'd3
  } ilace_e;

  function automatic logic field_toggles(input logic [1:0] mode);
    return mode[0];
  endfunction

  function automatic logic alt_lines(input logic [1:0] mode);
    return ilace_e'(mode) == ILACE_VIDEO;
  endfunction
endpackage

// File: rtl/crtc_hcount.sv
module crtc_hcount #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] h_total_i,
  input  logic [CW-1:0] hs_pos_i,
  input  logic [3:0]    hs_wid_i,
  output logic [CW-1:0] col_o,
  output logic          line_end_o,
  output logic          hsync_o
);
  logic [CW-1:0] col_q;
  logic [CW:0]   hs_stop;

  assign line_end_o = (col_q == h_total_i);
  assign hs_stop    = {1'b0, hs_pos_i} + (CW+1)'(hs_wid_i) - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         col_q <= '0;
    else if (line_end_o) col_q <= '0;
    else                 col_q <= col_q + 1'b1;
  end

  // pulse covers hs_wid-1 characters, clipped at line end
  assign hsync_o = (hs_wid_i > 4'd1) && (col_q >= hs_pos_i) &&
                   ({1'b0, col_q} < hs_stop);
  assign col_o   = col_q;
endmodule

// File: rtl/crtc_vcount.sv
module crtc_vcount
  import crtc_pkg::*;
#(
  parameter int CW = 8,
  parameter int LW = 5,
  parameter int AW = 16,
  parameter int FW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_end_i,
  input  logic [CW-1:0] v_total_i,
  input  logic [LW-1:0] cell_last_i,
  input  logic [LW-1:0] v_adj_i,
  input  logic [CW-1:0] vs_pos_i,
  input  logic [3:0]    vs_wid_i,
  input  logic [LW-1:0] scroll_i,
  input  logic [1:0]    ilace_i,
  input  logic [CW-1:0] h_disp_i,
  input  logic [CW-1:0] row_inc_i,
  output logic [CW-1:0] row_o,
  output logic [LW-1:0] line_o,
  output logic          in_adj_o,
  output logic          field_o,
  output logic          vsync_o,
  output logic [FW-1:0] frame_o,
  output logic [AW-1:0] row_off_o
);
  localparam int SW = LW + 2;

  logic [CW-1:0] row_q, row_n;
  logic [LW-1:0] line_q, line_n;
  logic          adj_q, adj_n, field_q, field_n;
  logic [AW-1:0] off_q, off_n;
  logic [4:0]    vs_cnt_q, vs_len;
  logic [FW-1:0] frame_q;
  logic [SW-1:0] offs, line_cur, step;
  logic          row_done, adj_done, wrap, row_start, vs_load;

  assign step     = alt_lines(ilace_i) ? SW'(2) : SW'(1);
  assign offs     = adj_q ? '0 :
                    ((row_q == '0) ? SW'(scroll_i) : '0) +
                    (alt_lines(ilace_i) ? SW'(field_q) : '0);
  assign line_cur = SW'(line_q) + offs;
  assign row_done = (line_cur + step) > SW'(cell_last_i);
  assign adj_done = (line_q == v_adj_i - 1'b1);
  assign vs_len   = (vs_wid_i == 4'd0) ? 5'd16 : {1'b0, vs_wid_i};

  always_comb begin
    row_n     = row_q;
    line_n    = line_q + (adj_q ? LW'(1) : LW'(step));
    adj_n     = adj_q;
    field_n   = field_q;
    off_n     = off_q;
    wrap      = 1'b0;
    row_start = 1'b0;
    if (adj_q) begin
      if (adj_done) wrap = 1'b1;
    end else if (row_done) begin
      if (row_q == v_total_i) begin
        if (v_adj_i != '0) begin
          adj_n  = 1'b1;
          line_n = '0;
        end else begin
          wrap = 1'b1;
        end
      end else begin
        row_n     = row_q + 1'b1;
        line_n    = '0;
        off_n     = off_q + AW'(h_disp_i) + AW'(row_inc_i);
        row_start = 1'b1;
      end
    end
    if (wrap) begin
      row_n     = '0;
      line_n    = '0;
      adj_n     = 1'b0;
      off_n     = '0;
      field_n   = field_toggles(ilace_i) ? ~field_q : 1'b0;
      row_start = 1'b1;
    end
  end

  assign vs_load = row_start && (row_n == vs_pos_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q    <= '0;
      line_q   <= '0;
      adj_q    <= 1'b0;
      field_q  <= 1'b0;
      off_q    <= '0;
      vs_cnt_q <= '0;
      frame_q  <= '0;
    end else if (line_end_i) begin
      row_q   <= row_n;
      line_q  <= line_n;
      adj_q   <= adj_n;
      field_q <= field_n;
      off_q   <= off_n;
      if (vs_load) begin
        vs_cnt_q <= vs_len;
        frame_q  <= frame_q + 1'b1;
      end else if (vs_cnt_q != '0) begin
        vs_cnt_q <= vs_cnt_q - 1'b1;
      end
    end
  end

  assign row_o     = row_q;
  assign line_o    = line_cur[LW-1:0];
  assign in_adj_o  = adj_q;
  assign field_o   = field_q;
  assign vsync_o   = (vs_cnt_q != '0);
  assign frame_o   = frame_q;
  assign row_off_o = off_q;
endmodule

// File: rtl/crtc_lpen.sv
module crtc_lpen #(
  parameter int CW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lpen_ni,
  input  logic          rd_i,
  input  logic [CW-1:0] row_i,
  input  logic [CW-1:0] col_i,
  output logic          fall_o,
  output logic [CW-1:0] lp_row_o,
  output logic [CW-1:0] lp_col_o,
  output logic          lp_flag_o
);
  logic [SYNC:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC-1:0], lpen_ni};
  end

  assign fall_o = sync_q[SYNC] & ~sync_q[SYNC-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lp_row_o  <= '0;
      lp_col_o  <= '0;
      lp_flag_o <= 1'b0;
    end else if (fall_o) begin
      lp_row_o  <= row_i;
      lp_col_o  <= col_i;
      lp_flag_o <= 1'b1;
    end else if (rd_i) begin
      lp_flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/crtc_timing.sv
module crtc_timing #(
  parameter int CW = 8,
  parameter int LW = 5,
  parameter int AW = 16,
  parameter int FW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] h_total_i,
  input  logic [CW-1:0] h_disp_i,
  input  logic [CW-1:0] hs_pos_i,
  input  logic [3:0]    hs_wid_i,
  input  logic [CW-1:0] hb_begin_i,
  input  logic [CW-1:0] hb_end_i,
  input  logic [CW-1:0] v_total_i,
  input  logic [CW-1:0] v_disp_i,
  input  logic [LW-1:0] cell_last_i,
  input  logic [LW-1:0] v_adj_i,
  input  logic [CW-1:0] vs_pos_i,
  input  logic [3:0]    vs_wid_i,
  input  logic [LW-1:0] scroll_i,
  input  logic [1:0]    ilace_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [CW-1:0] row_inc_i,
  input  logic          lpen_ni,
  input  logic          lp_rd_i,
  output logic [CW-1:0] col_o,
  output logic [CW-1:0] row_o,
  output logic [LW-1:0] line_o,
  output logic [AW-1:0] addr_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          blank_o,
  output logic          field_o,
  output logic [FW-1:0] frame_o,
  output logic [CW-1:0] lp_row_o,
  output logic [CW-1:0] lp_col_o,
  output logic          lp_flag_o
);
  logic          line_end, in_adj, hb_hit, pen_fall;
  logic [AW-1:0] row_off;

  crtc_hcount #(.CW(CW)) u_h (
    .clk_i, .rst_ni, .h_total_i, .hs_pos_i, .hs_wid_i,
    .col_o, .line_end_o(line_end), .hsync_o
  );

  crtc_vcount #(.CW(CW), .LW(LW), .AW(AW), .FW(FW)) u_v (
    .clk_i, .rst_ni, .line_end_i(line_end), .v_total_i, .cell_last_i,
    .v_adj_i, .vs_pos_i, .vs_wid_i, .scroll_i, .ilace_i, .h_disp_i,
    .row_inc_i, .row_o, .line_o, .in_adj_o(in_adj), .field_o, .vsync_o,
    .frame_o, .row_off_o(row_off)
  );

  crtc_lpen #(.CW(CW)) u_lpen (
    .clk_i, .rst_ni, .lpen_ni, .rd_i(lp_rd_i), .row_i(row_o), .col_i(col_o),
    .fall_o(pen_fall), .lp_row_o, .lp_col_o, .lp_flag_o
  );

  always_comb begin
    if (hb_begin_i < hb_end_i)
      hb_hit = (col_o >= hb_begin_i) && (col_o < hb_end_i);
    else if (hb_begin_i > hb_end_i)
      hb_hit = (col_o >= hb_begin_i) || (col_o < hb_end_i);
    else
      hb_hit = 1'b0;
  end

  assign de_o    = (col_o < h_disp_i) && (row_o < v_disp_i) && !in_adj;
  assign blank_o = !de_o || hb_hit;
  assign addr_o  = start_addr_i + row_off + AW'(col_o);
endmodule

// File: rtl/crtc_timing_chk.sv
module crtc_timing_chk #(
  parameter int CW = 8,
  parameter int LW = 5,
  parameter int FW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [CW-1:0] h_total_i,
  input logic [CW-1:0] h_disp_i,
  input logic [LW-1:0] cell_last_i,
  input logic [1:0]    ilace_i,
  input logic          lp_rd_i,
  input logic          pen_fall,
  input logic [CW-1:0] col_o,
  input logic [LW-1:0] line_o,
  input logic          vsync_o,
  input logic          de_o,
  input logic          blank_o,
  input logic          field_o,
  input logic [FW-1:0] frame_o,
  input logic [CW-1:0] lp_row_o,
  input logic [CW-1:0] lp_col_o,
  input logic          lp_flag_o
);
  assert_col_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_o == h_total_i |=> col_o == '0);
  assert_line_in_cell_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> line_o <= cell_last_i);
  assert_de_cols_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> col_o < h_disp_i);
  assert_blank_when_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_o |-> blank_o);
  assert_frame_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vsync_o) |-> frame_o == FW'($past(frame_o) + 1'b1));
  assert_frame_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(vsync_o) |-> $stable(frame_o));
  assert_field_fixed_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ilace_i[0] |=> !field_o);
  assert_pen_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pen_fall |=> $stable(lp_row_o) && $stable(lp_col_o));
  assert_flag_clear_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_rd_i && !pen_fall |=> !lp_flag_o);
endmodule

bind crtc_timing crtc_timing_chk #(.CW(CW), .LW(LW), .FW(FW)) u_chk (
  .clk_i, .rst_ni, .h_total_i, .h_disp_i, .cell_last_i, .ilace_i, .lp_rd_i,
  .pen_fall(pen_fall), .col_o, .line_o, .vsync_o, .de_o, .blank_o, .field_o,
  .frame_o, .lp_row_o, .lp_col_o, .lp_flag_o
);

// File: tb/crtc_timing_bench.sv
`timescale 1ns/1ps
module crtc_timing_bench;
  localparam int CW = 8, LW = 5, AW = 16, FW = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [CW-1:0] h_total, h_disp, hs_pos, hb_begin, hb_end, v_total, v_disp, vs_pos, row_inc;
  logic [3:0]    hs_wid, vs_wid;
  logic [LW-1:0] cell_last, v_adj, scroll;
  logic [1:0]    ilace;
  logic [AW-1:0] start_addr;
  logic          lpen_n = 1'b1, lp_rd = 1'b0;
  logic [CW-1:0] col, row, lp_row, lp_col;
  logic [LW-1:0] line;
  logic [AW-1:0] addr;
  logic          hsync, vsync, de, blank, field, lp_flag;
  logic [FW-1:0] frame;

  int checks = 0, errors = 0;
  int t, vs_left, fr_exp, pen_r, pen_c;
  bit first_line, pen_en;

  always #2.5 clk = ~clk;

  crtc_timing u_crtc_timing (
    .clk_i(clk), .rst_ni, .h_total_i(h_total), .h_disp_i(h_disp), .hs_pos_i(hs_pos),
    .hs_wid_i(hs_wid), .hb_begin_i(hb_begin), .hb_end_i(hb_end), .v_total_i(v_total),
    .v_disp_i(v_disp), .cell_last_i(cell_last), .v_adj_i(v_adj), .vs_pos_i(vs_pos),
    .vs_wid_i(vs_wid), .scroll_i(scroll), .ilace_i(ilace), .start_addr_i(start_addr),
    .row_inc_i(row_inc), .lpen_ni(lpen_n), .lp_rd_i(lp_rd), .col_o(col), .row_o(row),
    .line_o(line), .addr_o(addr), .hsync_o(hsync), .vsync_o(vsync), .de_o(de),
    .blank_o(blank), .field_o(field), .frame_o(frame), .lp_row_o(lp_row),
    .lp_col_o(lp_col), .lp_flag_o(lp_flag)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      if (errors < 20) $display("FAIL %s at t=%0d: actual %0d expected %0d", req, t, act, exp);
    end
  endtask

  task automatic pen_step();
    if (!pen_en) return;
    case (t)
      40: begin chk("R12 flag idle", lp_flag, 0); lpen_n = 1'b0; end
      42: begin pen_r = row; pen_r = -1; end
      default: ;
    endcase
  endtask

  task automatic one_cycle(int r, int ln, bit adj, int c, int fld);
    int exp_de, hb, exp_hs;
    exp_de = (c < h_disp && r < v_disp && !adj) ? 1 : 0;
    if (hb_begin < hb_end)      hb = (c >= hb_begin && c < hb_end) ? 1 : 0;
    else if (hb_begin > hb_end) hb = (c >= hb_begin || c < hb_end) ? 1 : 0;
    else                        hb = 0;
    exp_hs = (hs_wid > 1 && c >= hs_pos && c < hs_pos + hs_wid - 1) ? 1 : 0;
    chk("R1 col", col, c);
    chk("R3 row", row, r);
    chk("R3/R9/R11 line", line, ln);
    chk("R2 hsync", hsync, exp_hs);
    chk("R4 de", de, exp_de);
    chk("R4/R5 blank", blank, (exp_de == 0 || hb != 0) ? 1 : 0);
    if (exp_de != 0)
      chk("R6 addr", addr, (int'(start_addr) + r * (h_disp + row_inc) + c) & 32'hFFFF);
    chk("R7 vsync", vsync, vs_left > 0 ? 1 : 0);
    chk("R8 frame", frame, fr_exp);
    chk("R10 field", field, fld);
    if (pen_en) begin
      case (t)
        40: begin chk("R12 flag idle", lp_flag, 0); lpen_n = 1'b0; end
        42: begin pen_r = r; pen_c = c; end
        44: begin chk("R12 lp row", lp_row, pen_r); chk("R12 lp col", lp_col, pen_c);
                  chk("R12 flag set", lp_flag, 1); end
        46: lpen_n = 1'b1;
        49: begin chk("R12 single latch row", lp_row, pen_r);
                  chk("R12 single latch col", lp_col, pen_c); end
        50: lp_rd = 1'b1;
        51: lp_rd = 1'b0;
        52: begin chk("R13 flag cleared", lp_flag, 0); chk("R13 row kept", lp_row, pen_r);
                  chk("R13 col kept", lp_col, pen_c); end
        default: ;
      endcase
    end
    @(negedge clk);
    t++;
  endtask

  task automatic line_start(bit rs, int r);
    if (!first_line) begin
      if (rs && r == vs_pos) begin
        vs_left = (vs_wid == 0) ? 16 : vs_wid;
        fr_exp  = (fr_exp + 1) % 16;
      end else if (vs_left > 0) vs_left--;
    end
    first_line = 0;
  endtask

  task automatic run_cfg(int frames, bit pen);
    int fld, step, first;
    bit alt;
    rst_ni = 1'b0; lpen_n = 1'b1; lp_rd = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset col", col, 0);
    chk("R3 reset row", row, 0);
    chk("R7 reset vsync", vsync, 0);
    chk("R8 reset frame", frame, 0);
    chk("R12 reset flag", lp_flag, 0);
    rst_ni = 1'b1;
    t = 0; vs_left = 0; fr_exp = 0; first_line = 1; pen_en = pen; fld = 0;
    alt  = (ilace == 2'd3);
    step = alt ? 2 : 1;
    for (int f = 0; f < frames; f++) begin
      for (int r = 0; r <= v_total; r++) begin
        first = (r == 0 ? int'(scroll) : 0) + (alt ? fld : 0);
        for (int ln = first; ln <= cell_last; ln += step) begin
          line_start(ln == first, r);
          for (int c = 0; c <= h_total; c++) one_cycle(r, ln, 1'b0, c, fld);
        end
      end
      for (int a = 0; a < v_adj; a++) begin
        line_start(1'b0, v_total);
        for (int c = 0; c <= h_total; c++) one_cycle(v_total, a, 1'b1, c, fld);
      end
      fld = ilace[0] ? 1 - fld : 0;
    end
  endtask

  initial begin
    // config 1: plain, address wrap, normal blank window, light pen
    h_total = 11; h_disp = 8; hs_pos = 9; hs_wid = 3; hb_begin = 2; hb_end = 4;
    v_total = 4; v_disp = 3; cell_last = 3; v_adj = 2; vs_pos = 4; vs_wid = 3;
    scroll = 0; ilace = 2'd0; start_addr = 16'hFFF0; row_inc = 2;
    run_cfg(4, 1'b1);
    // config 2: scroll, field toggling, 16-line vsync across frame, wrapped window
    scroll = 2; ilace = 2'd1; vs_wid = 0; hb_begin = 10; hb_end = 1; row_inc = 0;
    start_addr = 16'd40;
    run_cfg(4, 1'b0);
    // config 3: alternating-line interlace, no adjust, empty window
    scroll = 0; ilace = 2'd3; v_adj = 0; hb_begin = 5; hb_end = 5; vs_wid = 2;
    hs_wid = 1; vs_pos = 2;
    run_cfg(4, 1'b0);
    // config 4: code 2 is non-interlaced, scroll 1, one adjust line
    ilace = 2'd2; scroll = 1; v_adj = 1; row_inc = 5; start_addr = 16'd100;
    hs_wid = 15; hs_pos = 6;
    run_cfg(4, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule